// File: doc/BRIEF.md
# HCI Link Control Responder

This block sits behind a byte deframer on the host side of a serial HCI transport. It sees each complete packet once, one byte per accepted beat, with the packet indicator byte first and a marker on the final byte. Packets that belong to the transport itself are answered locally. These are link negotiation, keep-alive and the vendor firmware-download record. The block checks each one against a fixed pattern and writes the reply bytes, one per cycle, into an outbound byte queue.

Ordinary command, ACL and SCO traffic goes out on a forward port without its indicator byte. A firmware record that carries a device address has that address pulled into a 48-bit register through a fixed byte permutation. Event packets coming from the host side, packets of unknown type, and malformed local packets raise a one-cycle error pulse and produce nothing else.

The input uses a valid/ready handshake. The block holds ready low while a reply is being emitted. It also holds ready low for one cycle after a forwarded command, because command bytes are forwarded one beat late: the block must see the opcode before it knows whether the packet stays local.

Top module: `hci_link_responder`

## Requirements
- R1: Out of reset, in_ready is 1, q_wr, fwd_valid and pkt_err are 0, and dev_addr is 0.
- R2: A packet of exactly 12 bytes equal to 06 0A 00 A0 01 00 00 4C 00 96 00 00 (indicator 06) is answered with 12 queue bytes: 06 0A 20, then received bytes 2 to 8 in order, then FF FF.
- R3: A packet with indicator 06 that differs from that template in any byte, or in length, gets no reply and raises pkt_err.
- R4: A packet with indicator 07 of exactly 4 bytes, with byte 2 equal to 55 and byte 3 equal to 00 (byte 1 is not checked), is answered with 07 02 CC 00. Any other indicator-07 packet gets no reply and raises pkt_err.
- R5: A command packet (indicator 01, opcode low byte at byte 1, high byte at byte 2) is a vendor command when opcode bits 15:10 are all ones. When its 10-bit command field is 0, it is answered with 14 bytes: 04 FF 0B followed by eleven 00 bytes.
- R6: A vendor command with a nonzero command field raises pkt_err. It is neither answered nor forwarded.
- R7: Parameter data starts at packet byte 4. If a vendor record of command field 0 is at least 30 bytes long, byte 16 is 01 and byte 17 is 00, then dev_addr bytes 0 to 5 (byte k at bits 8k+7:8k) take packet bytes 29, 28, 26, 22, 25 and 24. Otherwise dev_addr keeps its value, and the record is still answered.
- R8: Non-vendor commands (01), ACL (02) and SCO (03) packets are forwarded byte by byte without the indicator, in order, with fwd_last on the final byte. A one-byte packet forwards nothing.
- R9: Packets with indicator 04, or with any indicator other than 01, 02, 03, 06 and 07, raise pkt_err and produce no reply and no forwarded byte.
- R10: A reply byte is written (q_wr high) only in a cycle where q_full is low. While q_full is high, the reply pauses and then continues in order without losing bytes.
- R11: in_ready is 0 while a reply is being emitted, and for the one cycle after the final byte of a forwarded command of 3 or more bytes is accepted.
- R12: pkt_err is a pulse exactly one cycle long, in the cycle after the final byte of the offending packet is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input packet byte, indicator first |
| in_last | input | 1 | Input byte is the last of its packet |
| in_ready | output | 1 | Block accepts an input byte this cycle |
| fwd_valid | output | 1 | Forwarded byte valid |
| fwd_data | output | 8 | Forwarded byte |
| fwd_last | output | 1 | Forwarded byte ends the packet |
| q_full | input | 1 | Outbound queue cannot take a byte |
| q_wr | output | 1 | Write strobe into the outbound queue |
| q_data | output | 8 | Reply byte written into the queue |
| dev_addr | output | 48 | Device address loaded from a firmware record |
| pkt_err | output | 1 | One-cycle pulse for a rejected packet |

## Verification
The hardest state to reach is an address load that depends on the exact length and the marker bytes. A firmware record must be at least 30 bytes long, carry 01 then 00 at bytes 16 and 17, and its last address byte arrives in the same beat that ends the packet. The stimulus sends a 30-byte record with distinct data bytes so that each permutation slot is visible in dev_addr. It then sends a record with a wrong marker and a 29-byte record whose markers are correct, and checks that dev_addr does not move either time. Queue back-pressure is toggled in a fixed pattern while these replies drain, so that the reply pauses mid-sequence.

// File: rtl/hci_resp_pkg.sv
// Shared constants, reply kinds and byte tables for the HCI link responder.
// Assumes byte-wide packets with the indicator byte at index 0.
package hci_resp_pkg;

    typedef enum logic [1:0] {RK_NEG, RK_ALIVE, RK_VEND} reply_kind_e;

    localparam logic [7:0] T_CMD   = 8'h01;
    localparam logic [7:0] T_ACL   = 8'h02;
    localparam logic [7:0] T_SCO   = 8'h03;
    localparam logic [7:0] T_EVT   = 8'h04;
    localparam logic [7:0] T_NEG   = 8'h06;
    localparam logic [7:0] T_ALIVE = 8'h07;

    localparam int ECHO_N    = 7;   // echoed negotiation bytes
    localparam int ECHO_BASE = 3;   // reply position of the first echo byte
    localparam int NEG_LEN   = 12;
    localparam int ALIVE_LEN = 4;

    // Expected negotiation byte at position i.
    function automatic logic [7:0] neg_tmpl(input logic [3:0] i);
        case (i)
            4'd0:    return 8'h06;
            4'd1:    return 8'h0A;
            4'd3:    return 8'hA0;
            4'd4:    return 8'h01;
            4'd7:    return 8'h4C;
            4'd9:    return 8'h96;
            default: return 8'h00;
        endcase
    endfunction

    // Number of bytes in each reply.
    function automatic logic [4:0] reply_len(input reply_kind_e k);
        case (k)
            RK_NEG:   return 5'd12;
            RK_ALIVE: return 5'd4;
            default:  return 5'd14;
        endcase
    endfunction

    // Reply byte n of kind k; echo_b supplies the echoed negotiation byte.
    function automatic logic [7:0] reply_byte(input reply_kind_e k,
                                              input logic [4:0] n,
                                              input logic [7:0] echo_b);
        case (k)
            RK_NEG: begin
                case (n)
                    5'd0:         return 8'h06;
                    5'd1:         return 8'h0A;
                    5'd2:         return 8'h20;
                    5'd10, 5'd11: return 8'hFF;
                    default:      return echo_b;
                endcase
            end
            RK_ALIVE: begin
                case (n)
                    5'd0:    return 8'h07;
                    5'd1:    return 8'h02;
                    5'd2:    return 8'hCC;
                    default: return 8'h00;
                endcase
            end
            default: begin
                case (n)
                    5'd0:    return 8'h04;
                    5'd1:    return 8'hFF;
                    5'd2:    return 8'h0B;
                    default: return 8'h00;
                endcase
            end
        endcase
    endfunction

endpackage

// File: rtl/hci_reply_gen.sv
// Reply sequencer: on start, emits the bytes of one reply kind into the
// outbound queue, one per cycle while q_full is low. Also stores the
// negotiation bytes that the reply echoes. Assumes start never arrives
// while busy (the top holds input ready low then).
module hci_reply_gen
    import hci_resp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  reply_kind_e kind,
    input  logic        echo_we,
    input  logic [2:0]  echo_sel,
    input  logic [7:0]  echo_byte,
    input  logic        q_full,
    output logic        busy,
    output logic        q_wr,
    output logic [7:0]  q_data
);

    logic [7:0]       echo_q [ECHO_N];
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    reply_kind_e      kind_q;
    logic [7:0]       echo_b;
    logic [CNT_W-1:0] echo_idx;

    // Store negotiation bytes as they pass, for the echo.
    always_ff @(posedge clk) begin
        if (echo_we) echo_q[echo_sel] <= echo_byte;
    end

    // Pick the echoed byte for the current reply position.
    always_comb begin
        echo_idx = cnt_q - CNT_W'(ECHO_BASE);
        echo_b   = 8'h00;
        if (cnt_q >= CNT_W'(ECHO_BASE) && cnt_q < CNT_W'(ECHO_BASE + ECHO_N))
            echo_b = echo_q[echo_idx[2:0]];
    end

    assign busy   = active_q;
    assign q_wr   = active_q & ~q_full;
    assign q_data = reply_byte(kind_q, 5'(cnt_q), echo_b);

    // Step through the reply, holding while the queue is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            kind_q   <= RK_NEG;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            kind_q   <= kind;
        end else if (q_wr) begin
            if (5'(cnt_q) == reply_len(kind_q) - 5'd1) active_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: a full queue freezes the reply position.
    a_r10_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && q_full) |=> (active_q && cnt_q == $past(cnt_q)));

    // R2/R4/R5: every reply opens with its own indicator.
    a_r2_reply_head: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr && cnt_q == '0) |-> (q_data == 8'h06 || q_data == 8'h07 || q_data == 8'h04));

endmodule

// File: rtl/hci_fwd_lag.sv
// Forward path: passes ACL/SCO bytes through one register stage. Command
// bytes go out one beat late, so that the opcode high byte can mark a
// vendor command (kept local) before anything leaves. A one-cycle flush
// emits the held final byte. Assumes the consumer always accepts.
module hci_fwd_lag (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       is_cmd,
    input  logic       is_pass,
    input  logic       idx_one,
    input  logic       idx_two,
    input  logic       idx_ge1,
    input  logic       vend_hit,
    output logic       flush,
    output logic       fwd_valid,
    output logic [7:0] fwd_data,
    output logic       fwd_last
);

    logic [7:0] held_q;
    logic       lag_q;
    logic       flush_q;

    assign flush = flush_q;

    // Forward pass-through bytes directly and command bytes with a one-beat lag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_last  <= 1'b0;
            fwd_data  <= 8'h00;
            held_q    <= 8'h00;
            lag_q     <= 1'b0;
            flush_q   <= 1'b0;
        end else begin
            fwd_valid <= 1'b0;
            fwd_last  <= 1'b0;
            if (flush_q) begin
                fwd_valid <= 1'b1;
                fwd_last  <= 1'b1;
                fwd_data  <= held_q;
                flush_q   <= 1'b0;
            end else if (beat && idx_ge1) begin
                if (is_pass) begin
                    fwd_valid <= 1'b1;
                    fwd_data  <= in_data;
                    fwd_last  <= in_last;
                end else if (is_cmd) begin
                    if (idx_one) begin
                        held_q <= in_data;
                        if (in_last) begin
                            fwd_valid <= 1'b1;
                            fwd_data  <= in_data;
                            fwd_last  <= 1'b1;
                        end
                    end else if ((idx_two && !vend_hit) || lag_q) begin
                        fwd_valid <= 1'b1;
                        fwd_data  <= held_q;
                        held_q    <= in_data;
                        lag_q     <= !in_last;
                        flush_q   <= in_last;
                    end
                end
            end
        end
    end

    // R8: a packet end marker only rides on a valid byte.
    a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_last |-> fwd_valid);

    // R11: a flush cycle always delivers the closing command byte.
    a_r11_flush_closes: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |=> (fwd_valid && fwd_last));

endmodule

// File: rtl/hci_addr_grab.sv
// Device address capture: collects six bytes of a firmware record at
// permuted positions, plus two marker bytes, and loads the 48-bit address
// when the top flags a qualifying record end that is long enough.
// Assumes idx counts bytes from 0 at the indicator.
module hci_addr_grab #(
    parameter int IDX_W    = 8,
    parameter int MARK_IDX = 16,
    parameter int ADDR_IDX = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       in_data,
    input  logic             commit,
    output logic [47:0]      dev_addr
);

    localparam int NBYTES   = 6;
    localparam int MIN_LAST = ADDR_IDX + 7;

    // Offset inside the address field that feeds address byte k.
    function automatic int slot_off(input int k);
        case (k)
            0:       return 7;
            1:       return 6;
            2:       return 4;
            3:       return 0;
            4:       return 3;
            default: return 2;
        endcase
    endfunction

    logic [NBYTES-1:0][7:0] tmp_q, tmp_n;
    logic mark_lo_q, mark_hi_q, mark_lo_n, mark_hi_n;

    for (genvar k = 0; k < NBYTES; k++) begin : g_slot
        assign tmp_n[k] = (beat && idx == IDX_W'(ADDR_IDX + slot_off(k))) ? in_data : tmp_q[k];
    end

    // Marker tests, restarted at each packet's indicator.
    always_comb begin
        mark_lo_n = mark_lo_q;
        mark_hi_n = mark_hi_q;
        if (beat && idx == '0) begin
            mark_lo_n = 1'b0;
            mark_hi_n = 1'b0;
        end
        if (beat && idx == IDX_W'(MARK_IDX))     mark_lo_n = (in_data == 8'h01);
        if (beat && idx == IDX_W'(MARK_IDX + 1)) mark_hi_n = (in_data == 8'h00);
    end

    // Hold the candidate bytes and load the address on a qualifying end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_q     <= '0;
            mark_lo_q <= 1'b0;
            mark_hi_q <= 1'b0;
            dev_addr  <= '0;
        end else begin
            tmp_q     <= tmp_n;
            mark_lo_q <= mark_lo_n;
            mark_hi_q <= mark_hi_n;
            if (commit && mark_lo_n && mark_hi_n && idx >= IDX_W'(MIN_LAST))
                dev_addr <= tmp_n;
        end
    end

    // R7: the address moves only right after a record-end commit.
    a_r7_addr_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> $past(commit));

endmodule

// File: rtl/hci_link_responder.sv
// HCI link control responder (top). Classifies each incoming packet by its
// indicator and answers negotiation, keep-alive and vendor firmware records
// locally. Forwards other command/ACL/SCO traffic, loads a device address
// from firmware records, and pulses pkt_err for rejected packets. Assumes
// whole packets arrive with in_last on the final byte.
module hci_link_responder
    import hci_resp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        fwd_valid,
    output logic [7:0]  fwd_data,
    output logic        fwd_last,
    input  logic        q_full,
    output logic        q_wr,
    output logic [7:0]  q_data,
    output logic [47:0] dev_addr,
    output logic        pkt_err
);

    localparam logic [IDX_W-1:0] IDX_MAX = '1;
    localparam int REC_DATA_OFS = 4;
    localparam int MARK_IDX     = REC_DATA_OFS + 12;
    localparam int ADDR_IDX     = REC_DATA_OFS + 18;

    logic             beat, pkt_end, first, known;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       ptype_q, cur_type;
    logic             neg_ok_q, alive_ok_q, vend_q, ocf0_q, pkt_err_q;
    logic             neg_ok_n, alive_ok_n, vend_n, ocf0_n;
    logic             is_cmd, is_pass, neg_good, alive_good, vend_end, vend_good, bad;
    logic             rep_busy, flush, start, echo_we;
    reply_kind_e      kind;

    assign beat     = in_valid & in_ready;
    assign pkt_end  = beat & in_last;
    assign first    = (idx_q == '0);
    assign in_ready = ~rep_busy & ~flush;
    assign pkt_err  = pkt_err_q;

    // Per-byte pattern tests, folding in the current byte.
    always_comb begin
        cur_type   = first ? in_data : ptype_q;
        neg_ok_n   = (first | neg_ok_q) & (idx_q < IDX_W'(NEG_LEN))
                   & (in_data == neg_tmpl(idx_q[3:0]));
        alive_ok_n = (first | alive_ok_q) & (idx_q < IDX_W'(ALIVE_LEN))
                   & !(idx_q == IDX_W'(2) && in_data != 8'h55)
                   & !(idx_q == IDX_W'(3) && in_data != 8'h00);
        if (idx_q < IDX_W'(2))       vend_n = 1'b0;
        else if (idx_q == IDX_W'(2)) vend_n = (in_data[7:2] == 6'h3F);
        else                         vend_n = vend_q;
        if (idx_q == IDX_W'(1))      ocf0_n = (in_data == 8'h00);
        else if (idx_q == IDX_W'(2)) ocf0_n = ocf0_q & (in_data[1:0] == 2'b00);
        else                         ocf0_n = ocf0_q;
    end

    // Packet-end decisions: reply, reject or leave to the forward path.
    always_comb begin
        is_cmd     = (cur_type == T_CMD);
        is_pass    = (cur_type == T_ACL) | (cur_type == T_SCO);
        known      = is_cmd | is_pass | (cur_type == T_NEG) | (cur_type == T_ALIVE);
        neg_good   = pkt_end & (cur_type == T_NEG) & neg_ok_n & (idx_q == IDX_W'(NEG_LEN - 1));
        alive_good = pkt_end & (cur_type == T_ALIVE) & alive_ok_n & (idx_q == IDX_W'(ALIVE_LEN - 1));
        vend_end   = pkt_end & is_cmd & vend_n;
        vend_good  = vend_end & ocf0_n;
        bad        = pkt_end & (((cur_type == T_NEG) & !neg_good)
                              | ((cur_type == T_ALIVE) & !alive_good)
                              | (vend_end & !ocf0_n)
                              | !known);
        start      = neg_good | alive_good | vend_good;
        kind       = neg_good ? RK_NEG : (alive_good ? RK_ALIVE : RK_VEND);
        echo_we    = beat & (idx_q >= IDX_W'(2)) & (idx_q < IDX_W'(2 + ECHO_N));
    end

    // Track byte position, packet type and running test results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            ptype_q    <= 8'h00;
            neg_ok_q   <= 1'b0;
            alive_ok_q <= 1'b0;
            vend_q     <= 1'b0;
            ocf0_q     <= 1'b0;
            pkt_err_q  <= 1'b0;
        end else begin
            pkt_err_q <= bad;
            if (beat) begin
                if (first) ptype_q <= in_data;
                neg_ok_q   <= neg_ok_n;
                alive_ok_q <= alive_ok_n;
                vend_q     <= vend_n;
                ocf0_q     <= ocf0_n;
                if (in_last)               idx_q <= '0;
                else if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
            end
        end
    end

    hci_reply_gen #(.CNT_W(5)) u_reply (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind      (kind),
        .echo_we   (echo_we),
        .echo_sel  (3'(idx_q - IDX_W'(2))),
        .echo_byte (in_data),
        .q_full    (q_full),
        .busy      (rep_busy),
        .q_wr      (q_wr),
        .q_data    (q_data)
    );

    hci_fwd_lag u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (beat),
        .in_data   (in_data),
        .in_last   (in_last),
        .is_cmd    (is_cmd),
        .is_pass   (is_pass),
        .idx_one   (idx_q == IDX_W'(1)),
        .idx_two   (idx_q == IDX_W'(2)),
        .idx_ge1   (!first),
        .vend_hit  (vend_n),
        .flush     (flush),
        .fwd_valid (fwd_valid),
        .fwd_data  (fwd_data),
        .fwd_last  (fwd_last)
    );

    hci_addr_grab #(.IDX_W(IDX_W), .MARK_IDX(MARK_IDX), .ADDR_IDX(ADDR_IDX)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .idx      (idx_q),
        .in_data  (in_data),
        .commit   (vend_good),
        .dev_addr (dev_addr)
    );

    // R9: an event packet from the host is rejected with no reply.
    a_r9_event_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && cur_type == T_EVT) |=> (pkt_err && !rep_busy));

    // R12: a rejection never coincides with a running reply.
    a_r12_err_without_reply: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> !rep_busy);

    // R8: forwarding and replying never share a cycle.
    a_r8_no_mixed_output: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !q_wr);

endmodule

// File: tb/tb_hci_link_responder.sv
module tb_hci_link_responder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        fwd_valid;
    logic [7:0]  fwd_data;
    logic        fwd_last;
    logic        q_full;
    logic        q_wr;
    logic [7:0]  q_data;
    logic [47:0] dev_addr;
    logic        pkt_err;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    int exp_err = 0;
    int cyc = 0;
    bit full_mode = 1'b0;

    logic [7:0] pkt[$];
    logic [7:0] exp_q[$];
    logic [8:0] exp_f[$];
    logic [7:0] rec[26];

    always #(CLK_PERIOD/2) clk = ~clk;

    hci_link_responder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .fwd_valid(fwd_valid),
        .fwd_data(fwd_data), .fwd_last(fwd_last), .q_full(q_full),
        .q_wr(q_wr), .q_data(q_data), .dev_addr(dev_addr), .pkt_err(pkt_err)
    );

    // Queue back-pressure pattern, changed just after each rising edge.
    initial begin
        q_full = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            q_full = full_mode && (cyc % 3 != 0);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pop expected items as the design produces them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_err) err_seen++;
            if (q_full && q_wr) chk(1'b0, "R10 write while full", 48'(q_wr), 48'h0);
            if (q_wr) begin
                if (exp_q.size() == 0) chk(1'b0, "R2/R4/R5 unexpected reply byte", 48'(q_data), 48'h0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(q_data == e, "R2/R4/R5 reply byte", 48'(q_data), 48'(e));
                end
            end
            if (fwd_valid) begin
                if (exp_f.size() == 0) chk(1'b0, "R8 unexpected forward", 48'({fwd_last, fwd_data}), 48'h0);
                else begin
                    logic [8:0] f;
                    f = exp_f.pop_front();
                    chk({fwd_last, fwd_data} == f, "R8 forward byte", 48'({fwd_last, fwd_data}), 48'(f));
                end
            end
        end
    end

    // Driver: one byte per accepted beat; returns at the negedge after the last.
    task automatic send();
        for (int i = 0; i < pkt.size(); i++) begin
            in_valid = 1'b1;
            in_data  = pkt[i];
            in_last  = (i == pkt.size() - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic finish_pkt(input string req);
        repeat (60) @(negedge clk);
        chk(exp_q.size() == 0, req, 48'(exp_q.size()), 48'h0);
        chk(exp_f.size() == 0, req, 48'(exp_f.size()), 48'h0);
        chk(err_seen == exp_err, req, 48'(err_seen), 48'(exp_err));
    endtask

    task automatic push_vend_reply();
        exp_q.push_back(8'h04); exp_q.push_back(8'hFF); exp_q.push_back(8'h0B);
        for (int i = 0; i < 11; i++) exp_q.push_back(8'h00);
    endtask

    task automatic build_record(input int nbytes);
        pkt = '{8'h01, 8'h00, 8'hFC, 8'(nbytes - 4)};
        for (int d = 0; d < nbytes - 4; d++) pkt.push_back(rec[d]);
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] exp_addr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", 48'(in_ready), 48'h1);
        chk(!q_wr && !fwd_valid && !pkt_err, "R1 outputs idle", 48'({q_wr, fwd_valid, pkt_err}), 48'h0);
        chk(dev_addr == 48'h0, "R1 dev_addr", dev_addr, 48'h0);

        // R2 good negotiation, and R11 ready low during the reply
        pkt = '{8'h06, 8'h0A, 8'h00, 8'hA0, 8'h01, 8'h00, 8'h00, 8'h4C, 8'h00, 8'h96, 8'h00, 8'h00};
        exp_q.push_back(8'h06); exp_q.push_back(8'h0A); exp_q.push_back(8'h20);
        for (int i = 2; i <= 8; i++) exp_q.push_back(pkt[i]);
        exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
        send();
        chk(in_ready == 1'b0, "R11 ready low in reply", 48'(in_ready), 48'h0);
        finish_pkt("R2 negotiation");

        // R3 one byte wrong, then one byte short
        pkt = '{8'h06, 8'h0A, 8'h00, 8'hA0, 8'h01, 8'h01, 8'h00, 8'h4C, 8'h00, 8'h96, 8'h00, 8'h00};
        send();
        chk(pkt_err == 1'b1, "R12 err pulse timing", 48'(pkt_err), 48'h1);
        exp_err++;
        finish_pkt("R3 bad negotiation byte");
        pkt = '{8'h06, 8'h0A, 8'h00, 8'hA0, 8'h01, 8'h00, 8'h00, 8'h4C, 8'h00, 8'h96, 8'h00};
        send(); exp_err++;
        finish_pkt("R3 short negotiation");

        // R4 keep-alive good, bad value, bad length
        pkt = '{8'h07, 8'h33, 8'h55, 8'h00};
        exp_q.push_back(8'h07); exp_q.push_back(8'h02); exp_q.push_back(8'hCC); exp_q.push_back(8'h00);
        send();
        finish_pkt("R4 keep-alive");
        pkt = '{8'h07, 8'h00, 8'h55, 8'h01};
        send(); exp_err++;
        finish_pkt("R4 bad keep-alive value");
        pkt = '{8'h07, 8'h00, 8'h55, 8'h00, 8'h00};
        send(); exp_err++;
        finish_pkt("R4 long keep-alive");

        // R5 short firmware record: reply, R7 address untouched
        pkt = '{8'h01, 8'h00, 8'hFC, 8'h00};
        push_vend_reply();
        send();
        finish_pkt("R5 short record");
        chk(dev_addr == 48'h0, "R7 no address from short record", dev_addr, 48'h0);

        // R7 address-bearing record while the queue stalls (R10)
        for (int d = 0; d < 26; d++) rec[d] = 8'(8'h40 + d);
        rec[12] = 8'h01; rec[13] = 8'h00;
        exp_addr = {rec[20], rec[21], rec[18], rec[22], rec[24], rec[25]};
        build_record(30);
        push_vend_reply();
        full_mode = 1'b1;
        send();
        finish_pkt("R10 reply under back-pressure");
        full_mode = 1'b0;
        chk(dev_addr == exp_addr, "R7 address load", dev_addr, exp_addr);

        // R7 wrong marker: replied, address unchanged
        for (int d = 0; d < 26; d++) rec[d] = 8'(8'h80 + d);
        rec[12] = 8'h01; rec[13] = 8'h01;
        build_record(30);
        push_vend_reply();
        send();
        finish_pkt("R7 bad marker record");
        chk(dev_addr == exp_addr, "R7 address kept on bad marker", dev_addr, exp_addr);

        // R7 one byte too short, markers correct
        rec[13] = 8'h00;
        build_record(29);
        push_vend_reply();
        send();
        finish_pkt("R7 29-byte record");
        chk(dev_addr == exp_addr, "R7 address kept on short record", dev_addr, exp_addr);

        // R6 vendor command with nonzero command field
        pkt = '{8'h01, 8'h01, 8'hFC, 8'h00};
        send(); exp_err++;
        finish_pkt("R6 other vendor field");

        // R8 forwarded command, and R11 flush cycle
        pkt = '{8'h01, 8'h03, 8'h0C, 8'h00};
        exp_f.push_back(9'h003); exp_f.push_back(9'h00C); exp_f.push_back(9'h100);
        send();
        chk(in_ready == 1'b0, "R11 ready low in flush", 48'(in_ready), 48'h0);
        finish_pkt("R8 command forward");
        pkt = '{8'h01, 8'h55};
        exp_f.push_back(9'h155);
        send();
        finish_pkt("R8 two-byte command");
        pkt = '{8'h02, 8'h01, 8'h20, 8'h02, 8'h00, 8'hA5};
        for (int i = 1; i < 6; i++) exp_f.push_back({(i == 5), pkt[i]});
        send();
        finish_pkt("R8 ACL forward");
        pkt = '{8'h03, 8'h01, 8'h00, 8'h02, 8'hAA, 8'hBB};
        for (int i = 1; i < 6; i++) exp_f.push_back({(i == 5), pkt[i]});
        send();
        finish_pkt("R8 SCO forward");
        pkt = '{8'h02};
        send();
        finish_pkt("R8 one-byte packet");

        // R9 event packet and unknown indicator
        pkt = '{8'h04, 8'h0E, 8'h00};
        send(); exp_err++;
        finish_pkt("R9 event rejected");
        pkt = '{8'h09, 8'h00};
        send(); exp_err++;
        finish_pkt("R9 unknown rejected");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule